// File: doc/BRIEF.md
# Serial-Code Memory Access Lock

This block sits between a host's SRAM-style bus and a memory array. It keeps the array hidden until the host completes a fixed unlock ritual. While the array is locked, no host cycle reaches the memory. Every write cycle goes instead into a private code register, and read cycles drive the data line only during the identification phase.

The ritual has three steps. First, an arming event: a reset pulse at least `RST_MIN_CYC` clocks wide, or a completed dummy read. Second, `CODE_BITS` write cycles in a row, one bit each on the single data line, compared at the end against the hidden `SECRET` pattern. Third, on a match, `CODE_BITS` read cycles in a row, each returning one bit of the `ID_WORD` constant. After the last of those reads the gate opens and passes every cycle to the memory by address. Reset or a power-fail indication locks it again.

A bus cycle ends on the clock in which a sampled strobe (`bus_we` or `bus_rd`) falls while `bus_ce` is high. A written bit is the value `bus_din` had on the last clock with the strobe high. The bus has no back-pressure: every strobe edge is taken in the cycle it occurs, and this block never stalls the host.

Top module: `serial_lock_gate`

## Requirements
- R1: While `rst_n` is low, and after any reset, the gate is locked: `mem_ce`, `mem_we` and `bus_q_oe` are 0 whatever the bus does.
- R2: A low pulse on `rst_n` of at least `RST_MIN_CYC` clocks (default 20 = 200 ns at 100 MHz) arms the code phase once `rst_n` returns high. A shorter pulse only locks. From the idle locked state, a completed read cycle also arms the code phase.
- R3: Until unlocked, `mem_ce` and `mem_we` stay 0 for any bus activity.
- R4: In the code phase, each completed write cycle takes one bit from `bus_din`, least-significant bit first (the first write is bit 0). Write cycles in the idle locked state have no effect.
- R5: A completed read cycle in the code phase aborts the sequence to idle. That read does not re-arm. A read end and a write end in the same clock also abort.
- R6: After the last code write, a match with `SECRET` enters the identification phase; a mismatch returns to idle.
- R7: In the identification phase, while `bus_ce` and `bus_rd` are high, `bus_q_oe` is 1 and `bus_q` is bit k of `ID_WORD`, where k is the count of completed reads in that phase (LSB first).
- R8: A completed write cycle in the identification phase aborts to idle, including when a read ends in the same clock.
- R9: From the clock after the last identification read: `mem_ce` = `bus_ce`, `mem_we` = `bus_ce & bus_we`, `bus_q_oe` = `bus_ce & bus_rd`, and `bus_q` = `mem_q`.
- R10: `pwr_fail` high locks the gate and returns it to idle from any phase on the next clock.
- R11: A strobe that falls while `bus_ce` is low is not a cycle and has no effect in any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled; its width decides arming |
| pwr_fail | input | 1 | Supply-low indication, high forces relock |
| bus_ce | input | 1 | Host chip enable, active high |
| bus_we | input | 1 | Host write strobe, active high |
| bus_rd | input | 1 | Host read strobe, active high |
| bus_din | input | 1 | Host data line, host to gate |
| bus_q | output | 1 | Data line, gate to host |
| bus_q_oe | output | 1 | Gate drives the data line |
| mem_q | input | 1 | Read data from the memory array |
| mem_ce | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write enable |

## Verification
A write strobe and a read strobe can end in the same clock. The sequencer must then settle which one wins: the read wins in the code phase, and the write wins in the identification phase. The bench lowers both strobes together once in each phase. A behavioural model with the same priority rules then shows, on every clock, whether later read-outs and memory enables still follow an aborted sequence. Power-fail arriving in the same clock as a strobe end is covered by the same comparison.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CODE = 2'd1,
    PH_ID   = 2'd2,
    PH_OPEN = 2'd3
  } phase_t;
endpackage

// File: rtl/lsl_strobe.sv
// Turns host strobe falls (qualified by chip enable) into single-clock cycle-end pulses.
module lsl_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce,
  input  logic bus_we,
  input  logic bus_rd,
  input  logic bus_din,
  output logic wr_end,
  output logic rd_end,
  output logic bit_cap
);
  logic we_q, rd_q, din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      rd_q  <= 1'b0;
      din_q <= 1'b0;
    end else begin
      we_q  <= bus_we;
      rd_q  <= bus_rd;
      din_q <= bus_din;
    end
  end

  assign wr_end  = bus_ce & we_q & ~bus_we;
  assign rd_end  = bus_ce & rd_q & ~bus_rd;
  assign bit_cap = din_q;
endmodule

// File: rtl/lsl_rst_qual.sv
// Measures the low time of the reset line; flags a long enough pulse on its release.
module lsl_rst_qual #(
  parameter int RST_MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic arm
);
  localparam int CW = $clog2(RST_MIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_MIN_CYC);

  logic [CW-1:0] low_cnt = '0;
  logic          rst_q   = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (rst_n)
      low_cnt <= '0;
    else if (low_cnt != LIM)
      low_cnt <= low_cnt + 1'b1;
  end

  assign arm = rst_n & ~rst_q & (low_cnt == LIM);
endmodule

// File: rtl/lsl_code_sr.sv
// Holds the write-only code bits and predicts the compare result of the pending shift.
module lsl_code_sr #(
  parameter int W = 64,
  parameter logic [W-1:0] SECRET = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  output logic match_next
);
  logic [W-1:0] sr;
  logic [W-1:0] cand;

  assign cand = {bit_in, sr[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      sr <= '0;
    else if (shift_en)
      sr <= cand;
  end

  assign match_next = (cand == SECRET);
endmodule

// File: rtl/serial_lock_gate.sv
module serial_lock_gate #(
  parameter int CODE_BITS = 64,
  parameter logic [CODE_BITS-1:0] SECRET  = 64'hA5C3_0F1E_7B29_D486,
  parameter logic [CODE_BITS-1:0] ID_WORD = 64'h3C5A_96E1_0FF0_1234,
  parameter int RST_MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic bus_ce,
  input  logic bus_we,
  input  logic bus_rd,
  input  logic bus_din,
  output logic bus_q,
  output logic bus_q_oe,
  input  logic mem_q,
  output logic mem_ce,
  output logic mem_we
);
  import lsl_pkg::*;

  localparam int IDX_W = $clog2(CODE_BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CODE_BITS - 1);

  logic wr_end, rd_end, bit_cap, arm, match_next, shift_en;
  phase_t phase;
  logic [IDX_W-1:0] idx;

  lsl_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we), .bus_rd(bus_rd),
    .bus_din(bus_din), .wr_end(wr_end), .rd_end(rd_end), .bit_cap(bit_cap)
  );

  lsl_rst_qual #(.RST_MIN_CYC(RST_MIN_CYC)) u_rstq (
    .clk(clk), .rst_n(rst_n), .arm(arm)
  );

  assign shift_en = (phase == PH_CODE) & wr_end & ~rd_end & ~pwr_fail;

  lsl_code_sr #(.W(CODE_BITS), .SECRET(SECRET)) u_code (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(bit_cap),
    .match_next(match_next)
  );

  // phase sequencer: read wins in code phase, write wins in id phase
  always_ff @(posedge clk) begin
    if (!rst_n || pwr_fail) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (arm || rd_end) begin
            phase <= PH_CODE;
            idx   <= '0;
          end
        end
        PH_CODE: begin
          if (rd_end) begin
            phase <= PH_IDLE;
            idx   <= '0;
          end else if (wr_end) begin
            if (idx == LAST) begin
              phase <= match_next ? PH_ID : PH_IDLE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_ID: begin
          if (wr_end) begin
            phase <= PH_IDLE;
            idx   <= '0;
          end else if (rd_end) begin
            if (idx == LAST) begin
              phase <= PH_OPEN;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: phase <= PH_OPEN;
      endcase
    end
  end

  logic is_open;
  assign is_open  = (phase == PH_OPEN);
  assign mem_ce   = bus_ce & is_open;
  assign mem_we   = bus_ce & bus_we & is_open;
  assign bus_q_oe = bus_ce & bus_rd & (is_open | (phase == PH_ID));
  assign bus_q    = is_open ? mem_q : ID_WORD[idx];

  a_r3_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_OPEN) |-> (!mem_ce && !mem_we));

  a_r5_read_aborts_code: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CODE && rd_end) |=> (phase == PH_IDLE));

  a_r6_mismatch_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CODE && wr_end && !rd_end && idx == LAST && !match_next) |=> (phase == PH_IDLE));

  a_r8_write_aborts_id: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ID && wr_end) |=> (phase == PH_IDLE));

  a_r9_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPEN && !pwr_fail) |=> (phase == PH_OPEN));

  a_r10_pwr_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (phase == PH_IDLE));
endmodule

// File: tb/serial_lock_gate_test.sv
module serial_lock_gate_test;
  localparam logic [63:0] SEC = 64'hA5C3_0F1E_7B29_D486;
  localparam logic [63:0] IDW = 64'h3C5A_96E1_0FF0_1234;
  localparam int RMIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_fail = 1'b0;
  logic bus_ce = 1'b0, bus_we = 1'b0, bus_rd = 1'b0, bus_din = 1'b0;
  logic bus_q, bus_q_oe, mem_ce, mem_we, mem_q;
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  assign mem_q = cyc[2] ^ cyc[0];

  serial_lock_gate uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .bus_ce(bus_ce), .bus_we(bus_we),
    .bus_rd(bus_rd), .bus_din(bus_din), .bus_q(bus_q), .bus_q_oe(bus_q_oe),
    .mem_q(mem_q), .mem_ce(mem_ce), .mem_we(mem_we)
  );

  // behavioural reference: 0 idle, 1 code, 2 id, 3 open
  int m_ph = 0, m_k = 0, m_low = 0;
  logic [63:0] m_code = '0;
  logic m_we_p = 0, m_rd_p = 0, m_din_p = 0, m_rst_p = 0;

  always @(posedge clk) begin
    bit we_e, rd_e, armed;
    cyc <= cyc + 1;
    we_e  = bus_ce && m_we_p && !bus_we;
    rd_e  = bus_ce && m_rd_p && !bus_rd;
    armed = rst_n && !m_rst_p && (m_low >= RMIN);
    if (!rst_n || pwr_fail) begin
      m_ph = 0; m_k = 0;
    end else if (m_ph == 0) begin
      if (armed || rd_e) begin m_ph = 1; m_k = 0; end
    end else if (m_ph == 1) begin
      if (rd_e) begin m_ph = 0; m_k = 0; end
      else if (we_e) begin
        m_code[m_k] = m_din_p;
        if (m_k == 63) begin m_ph = (m_code == SEC) ? 2 : 0; m_k = 0; end
        else m_k++;
      end
    end else if (m_ph == 2) begin
      if (we_e) begin m_ph = 0; m_k = 0; end
      else if (rd_e) begin
        if (m_k == 63) begin m_ph = 3; m_k = 0; end
        else m_k++;
      end
    end
    m_low   = rst_n ? 0 : m_low + 1;
    m_rst_p = rst_n;
    m_we_p  = rst_n ? bus_we : 1'b0;
    m_rd_p  = rst_n ? bus_rd : 1'b0;
    m_din_p = rst_n ? bus_din : 1'b0;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic e_oe;
      string rq;
      e_oe = bus_ce && bus_rd && (m_ph == 2 || m_ph == 3);
      rq = (m_ph == 3) ? "R9" : (!rst_n ? "R1" : cur_req);
      check(rq, "mem_ce", mem_ce, bus_ce && (m_ph == 3));
      check(rq, "mem_we", mem_we, bus_ce && bus_we && (m_ph == 3));
      check(rq, "bus_q_oe", bus_q_oe, e_oe);
      if (e_oe)
        check((m_ph == 2) ? "R7" : "R9", "bus_q", bus_q, (m_ph == 3) ? mem_q : IDW[m_k]);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_bit(input logic b, input logic ce);
    bus_ce = ce; bus_we = 1'b1; bus_din = b; tick(2);
    bus_we = 1'b0; tick(1);
    bus_ce = 1'b0; bus_din = ~b; tick(1);
  endtask

  task automatic rd_cyc(input logic ce);
    bus_ce = ce; bus_rd = 1'b1; tick(2);
    bus_rd = 1'b0; tick(1);
    bus_ce = 1'b0; tick(1);
  endtask

  task automatic both_end();
    bus_ce = 1'b1; bus_we = 1'b1; bus_rd = 1'b1; bus_din = 1'b1; tick(2);
    bus_we = 1'b0; bus_rd = 1'b0; tick(1);
    bus_ce = 1'b0; tick(1);
  endtask

  task automatic pulse_rst(input int n);
    rst_n = 1'b0; tick(n);
    rst_n = 1'b1; tick(2);
  endtask

  task automatic send_code(input logic [63:0] c);
    for (int i = 0; i < 64; i++) wr_bit(c[i], 1'b1);
  endtask

  task automatic read_id(input int n);
    for (int i = 0; i < n; i++) rd_cyc(1'b1);
  endtask

  task automatic probe();
    wr_bit(1'b1, 1'b1);
    rd_cyc(1'b1);
  endtask

  initial begin
    cur_req = "R1"; tick(30);
    rst_n = 1'b1; tick(2);
    probe();
    // long reset armed the code phase; the probe write counted as bit 0, so restart
    cur_req = "R2"; pulse_rst(25);
    cur_req = "R4"; send_code(SEC);
    cur_req = "R7"; read_id(64);
    cur_req = "R9"; probe(); probe();

    cur_req = "R10"; pwr_fail = 1'b1; tick(2); pwr_fail = 1'b0; tick(1);
    probe(); read_id(3);

    cur_req = "R2"; pulse_rst(5);
    cur_req = "R4"; send_code(SEC);
    cur_req = "R3"; read_id(64); probe();
    cur_req = "R2"; rd_cyc(1'b1);
    send_code(SEC); read_id(64); probe();

    cur_req = "R6"; pulse_rst(RMIN);
    send_code(SEC ^ 64'h1);
    read_id(64); probe();

    cur_req = "R5"; pulse_rst(RMIN + 3);
    send_code(SEC & 64'h3FF);
    rd_cyc(1'b1);
    send_code(SEC); read_id(64); probe();

    cur_req = "R5"; pulse_rst(RMIN);
    for (int i = 0; i < 7; i++) wr_bit(SEC[i], 1'b1);
    both_end();
    rd_cyc(1'b1); send_code(SEC); read_id(64); probe();

    cur_req = "R8"; pulse_rst(RMIN);
    send_code(SEC); read_id(5);
    wr_bit(1'b0, 1'b1);
    read_id(64); probe();

    cur_req = "R8"; pulse_rst(RMIN);
    send_code(SEC); read_id(9);
    both_end();
    read_id(64); probe();

    cur_req = "R11"; pulse_rst(RMIN);
    for (int i = 0; i < 64; i++) begin
      wr_bit(~SEC[i], 1'b0);
      rd_cyc(1'b0);
      wr_bit(SEC[i], 1'b1);
    end
    for (int i = 0; i < 64; i++) begin
      wr_bit(1'b0, 1'b0);
      rd_cyc(1'b1);
    end
    probe();

    cur_req = "R10"; pwr_fail = 1'b1; bus_ce = 1'b1; bus_we = 1'b1; tick(1);
    bus_we = 1'b0; tick(1); pwr_fail = 1'b0; bus_ce = 1'b0; tick(1);
    probe();
    finish_run();
  end
endmodule